// File: doc/BRIEF.md
# Descriptor-Driven Memory Copy Engine

This block is a bus master that moves words from one memory address to another with no processor involvement. The work to do is described by a four-word descriptor held in memory. When a run is triggered, the engine reads the descriptor, copies the requested number of words one at a time, writes the updated counters and addresses back into the descriptor, and reports the outcome with a one-cycle interrupt pulse. Successful completion and a failed bus access raise different pulses.

A run is triggered in one of three ways. Software can pulse a start input with a descriptor address. A peripheral can hold a request line high, in which case the engine finds the first descriptor through a per-line pointer table in memory. A finished descriptor can also chain straight into the next one, or into itself again. Two reload options control repetition. The inner option repeats the same block of words inside one run. The outer option leaves the descriptor unchanged after a run, so the next trigger repeats the whole transfer.

The memory port is a plain 32-bit request/ready/error handshake on a bus that belongs to this engine alone.

Top module: `dxfer_ctrl`

## Requirements
- R1: A descriptor at byte address A is four words, read in this order: A+0 is the config word, A+4 is the count word, A+8 is the source address and A+12 is the destination address. Count word bits 15:0 give the beats per block and bits 31:16 give the number of blocks. Config word bits: bit 0 enables chaining; bit 1 selects the chain target, 1 for the same descriptor and 0 for A+16; bit 2 enables inner reload; bit 3 enables outer reload.
- R2: Each beat reads one word at the source address and writes it to the destination address. Both addresses then advance by 4. A run moves blocks × beats-per-block words.
- R3: A sw_start pulse while idle starts a run at sw_desc_addr, and it takes precedence over hardware requests in the same cycle. With a memory that is always ready, irq_done is high after the (8+2N)-th clock edge following the edge that samples sw_start, where N is the number of beats. With outer reload set it is high after the (5+2N)-th edge.
- R4: While mem_ready is low, mem_req stays high and mem_addr, mem_we and mem_wdata hold their values. Data still moves correctly when the memory inserts random wait states.
- R5: With inner reload set, both addresses return to their start values at every block boundary except the last, so every block copies the same words. With inner reload clear, the addresses keep advancing.
- R6: With outer reload clear, the end of a run writes the count word as 0 and writes back the source and destination addresses that follow the last beat. With outer reload set, the descriptor is left unchanged.
- R7: A descriptor that moves data, has chaining enabled and ends normally fetches its chain target with no new trigger. irq_done pulses once, after the last descriptor of the chain. A descriptor with a zero count field moves no data, writes back unchanged values and does not chain.
- R8: A high hw_req[c] for c < NUM_HW_CH while the engine is idle starts a run. The first descriptor address is read from table_base + 4c. The lowest pending channel is served first. hw_ack[c] pulses for one cycle when that run ends.
- R9: Requests on hw_req[c] for c >= NUM_HW_CH are ignored. busy stays low and no memory request is issued.
- R10: mem_err together with mem_ready on any access aborts the run. irq_err pulses, irq_done does not, and no later write-back takes place. err_desc holds the address of the descriptor being processed, or the table entry address for a failing pointer read.
- R11: irq_done and irq_err are single-cycle pulses that are never high together. busy is low after reset and whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software trigger, sampled while idle |
| sw_desc_addr | input | 32 | Descriptor address for a software trigger |
| table_base | input | 32 | Base address of the per-channel pointer table |
| hw_req | input | 256 | Level request per hardware channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Access completes in this cycle |
| mem_err | input | 1 | Access failed, qualified by mem_ready |
| busy | output | 1 | A run is in progress |
| irq_done | output | 1 | Normal-end pulse |
| irq_err | output | 1 | Abnormal-end pulse |
| err_desc | output | 32 | Descriptor address latched on an abort |
| hw_ack | output | 256 | One-cycle end-of-run pulse for the served channel |

## Verification
Most results are due only at the end of a run, after a delay that depends on descriptor length and memory wait states. So the bench waits for the first irq_done, irq_err or hw_ack pulse, with a per-run cycle limit, and only then compares memory and descriptor contents with values from its own model of the copy. For the one exact timing rule, the bench holds the memory ready on every cycle and counts clock edges from the sampling of sw_start. It expects the pulse after exactly 8+2N edges, or 5+2N edges with outer reload. Ignored requests are checked by sampling busy and mem_req on every cycle of a fixed window. Pulse width is checked on the cycle right after the event.

// File: rtl/dxf_pkg.sv
package dxf_pkg;
   localparam int ADDR_W   = 32;
   localparam int CNT_W    = 16;
   localparam int HW_LINES = 256;
   localparam int DESC_BYTES = 16;

   typedef enum logic [2:0] {
      S_IDLE, S_PTR, S_FETCH, S_RD, S_WR, S_WB, S_FIN
   } dxf_state_e;

   typedef struct packed {
      logic outer_rl;
      logic inner_rl;
      logic chain_same;
      logic chain_en;
   } dxf_cfg_t;
endpackage

// File: rtl/dxf_trig_sel.sv
module dxf_trig_sel #(
   parameter int NUM_HW_CH = 64,
   parameter int LINES     = 256,
   localparam int IDX_W    = $clog2(LINES)
) (
   input  logic [LINES-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   logic [NUM_HW_CH-1:0] live;
   assign live = req[NUM_HW_CH-1:0];

   generate
      if (NUM_HW_CH < LINES) begin : g_drop
         logic unused_hi;
         assign unused_hi = ^req[LINES-1:NUM_HW_CH];
      end
   endgenerate

   // lowest-numbered live request wins
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int c = NUM_HW_CH-1; c >= 0; c--) begin
         if (live[c]) begin
            any = 1'b1;
            idx = IDX_W'(c);
         end
      end
   end
endmodule

// File: rtl/dxf_xfer_cnt.sv
module dxf_xfer_cnt #(
   parameter int CNT_W = 16,
   parameter int AW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_cnt,
   input  logic             ld_src,
   input  logic             ld_dst,
   input  logic [AW-1:0]    ld_val,
   input  logic             beat_done,
   input  logic             inner_rl,
   output logic [AW-1:0]    src,
   output logic [AW-1:0]    dst,
   output logic [CNT_W-1:0] inner_rem,
   output logic [CNT_W-1:0] outer_rem,
   output logic             last_beat,
   output logic             zero_cnt
);
   localparam logic [AW-1:0] STEP = AW'(4);

   generate
      if (2*CNT_W != AW) begin : g_bad_cnt
         $error("count word must hold exactly two count fields");
      end
   endgenerate

   logic [CNT_W-1:0] in_start;
   logic [AW-1:0]    src_start, dst_start;

   assign last_beat = (inner_rem == CNT_W'(1)) && (outer_rem == CNT_W'(1));
   assign zero_cnt  = (inner_rem == '0) || (outer_rem == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_start  <= '0;
         inner_rem <= '0;
         outer_rem <= '0;
         src_start <= '0;
         dst_start <= '0;
         src       <= '0;
         dst       <= '0;
      end else begin
         if (ld_cnt) begin
            in_start  <= ld_val[CNT_W-1:0];
            inner_rem <= ld_val[CNT_W-1:0];
            outer_rem <= ld_val[2*CNT_W-1:CNT_W];
         end
         if (ld_src) begin
            src_start <= ld_val;
            src       <= ld_val;
         end
         if (ld_dst) begin
            dst_start <= ld_val;
            dst       <= ld_val;
         end
         if (beat_done) begin
            if (inner_rem == CNT_W'(1) && outer_rem != CNT_W'(1)) begin
               // block boundary inside the run
               inner_rem <= in_start;
               outer_rem <= outer_rem - CNT_W'(1);
               src <= inner_rl ? src_start : src + STEP;
               dst <= inner_rl ? dst_start : dst + STEP;
            end else begin
               inner_rem <= inner_rem - CNT_W'(1);
               if (inner_rem == CNT_W'(1)) outer_rem <= '0;
               src <= src + STEP;
               dst <= dst + STEP;
            end
         end
      end
   end
endmodule

// File: rtl/dxfer_ctrl.sv
module dxfer_ctrl
   import dxf_pkg::*;
#(
   parameter int NUM_HW_CH = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sw_start,
   input  logic [ADDR_W-1:0]     sw_desc_addr,
   input  logic [ADDR_W-1:0]     table_base,
   input  logic [HW_LINES-1:0]   hw_req,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [ADDR_W-1:0]     mem_wdata,
   input  logic [ADDR_W-1:0]     mem_rdata,
   input  logic                  mem_ready,
   input  logic                  mem_err,
   output logic                  busy,
   output logic                  irq_done,
   output logic                  irq_err,
   output logic [ADDR_W-1:0]     err_desc,
   output logic [HW_LINES-1:0]   hw_ack
);
   localparam int IDX_W = $clog2(HW_LINES);

   generate
      if (NUM_HW_CH != 64 && NUM_HW_CH != 128 && NUM_HW_CH != 256) begin : g_bad_ch
         $error("NUM_HW_CH must be 64, 128 or 256");
      end
   endgenerate

   dxf_state_e         st;
   dxf_cfg_t           cfg;
   logic [1:0]         widx;
   logic [ADDR_W-1:0]  cur_desc, dbuf;
   logic               from_hw, moved;
   logic [IDX_W-1:0]   hw_ch, hw_idx;
   logic               hw_any;

   logic [ADDR_W-1:0]  src, dst;
   logic [CNT_W-1:0]   inner_rem, outer_rem;
   logic               last_beat, zero_cnt;
   logic               acc_done, acc_ok, acc_bad;

   dxf_trig_sel #(.NUM_HW_CH(NUM_HW_CH), .LINES(HW_LINES)) u_sel (
      .req(hw_req), .any(hw_any), .idx(hw_idx)
   );

   assign acc_done = mem_req && mem_ready;
   assign acc_bad  = acc_done && mem_err;
   assign acc_ok   = acc_done && !mem_err;

   dxf_xfer_cnt #(.CNT_W(CNT_W), .AW(ADDR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .ld_cnt(st == S_FETCH && acc_ok && widx == 2'd1),
      .ld_src(st == S_FETCH && acc_ok && widx == 2'd2),
      .ld_dst(st == S_FETCH && acc_ok && widx == 2'd3),
      .ld_val(mem_rdata),
      .beat_done(st == S_WR && acc_ok),
      .inner_rl(cfg.inner_rl),
      .src(src), .dst(dst),
      .inner_rem(inner_rem), .outer_rem(outer_rem),
      .last_beat(last_beat), .zero_cnt(zero_cnt)
   );

   assign busy = (st != S_IDLE);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st)
         S_PTR:   begin mem_req = 1'b1; mem_addr = cur_desc; end
         S_FETCH: begin mem_req = 1'b1; mem_addr = cur_desc + ADDR_W'({widx, 2'b00}); end
         S_RD:    begin mem_req = 1'b1; mem_addr = src; end
         S_WR:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst; mem_wdata = dbuf; end
         S_WB: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = cur_desc + ADDR_W'(4) + ADDR_W'({widx, 2'b00});
            case (widx)
               2'd0:    mem_wdata = {outer_rem, inner_rem};
               2'd1:    mem_wdata = src;
               default: mem_wdata = dst;
            endcase
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cfg      <= '0;
         widx     <= '0;
         cur_desc <= '0;
         dbuf     <= '0;
         from_hw  <= 1'b0;
         moved    <= 1'b0;
         hw_ch    <= '0;
         irq_done <= 1'b0;
         irq_err  <= 1'b0;
         err_desc <= '0;
         hw_ack   <= '0;
      end else begin
         irq_done <= 1'b0;
         irq_err  <= 1'b0;
         hw_ack   <= '0;
         if (acc_bad) begin
            irq_err  <= 1'b1;
            err_desc <= cur_desc;
            if (from_hw) hw_ack[hw_ch] <= 1'b1;
            st <= S_IDLE;
         end else begin
            unique case (st)
               S_IDLE: begin
                  widx <= '0;
                  if (sw_start) begin
                     cur_desc <= sw_desc_addr;
                     from_hw  <= 1'b0;
                     st       <= S_FETCH;
                  end else if (hw_any) begin
                     cur_desc <= table_base + ADDR_W'({hw_idx, 2'b00});
                     hw_ch    <= hw_idx;
                     from_hw  <= 1'b1;
                     st       <= S_PTR;
                  end
               end
               S_PTR: if (acc_ok) begin
                  cur_desc <= mem_rdata;
                  st       <= S_FETCH;
               end
               S_FETCH: if (acc_ok) begin
                  if (widx == 2'd0) cfg <= dxf_cfg_t'(mem_rdata[3:0]);
                  widx <= widx + 2'd1;
                  if (widx == 2'd3) begin
                     moved <= !zero_cnt;
                     if (!zero_cnt)        st <= S_RD;
                     else if (cfg.outer_rl) st <= S_FIN;
                     else                  st <= S_WB;
                  end
               end
               S_RD: if (acc_ok) begin
                  dbuf <= mem_rdata;
                  st   <= S_WR;
               end
               S_WR: if (acc_ok) begin
                  widx <= '0;
                  if (!last_beat)        st <= S_RD;
                  else if (cfg.outer_rl) st <= S_FIN;
                  else                   st <= S_WB;
               end
               S_WB: if (acc_ok) begin
                  widx <= widx + 2'd1;
                  if (widx == 2'd2) st <= S_FIN;
               end
               S_FIN: begin
                  widx <= '0;
                  if (cfg.chain_en && moved) begin
                     if (!cfg.chain_same) cur_desc <= cur_desc + ADDR_W'(DESC_BYTES);
                     st <= S_FETCH;
                  end else begin
                     irq_done <= 1'b1;
                     if (from_hw) hw_ack[hw_ch] <= 1'b1;
                     st <= S_IDLE;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/dxfer_ctrl_chk.sv
module dxfer_ctrl_chk #(
   parameter int NUM_HW_CH = 64
) (
   input logic         clk,
   input logic         rst_n,
   input logic         sw_start,
   input logic         busy,
   input logic         mem_req,
   input logic         mem_ready,
   input logic         mem_we,
   input logic [31:0]  mem_addr,
   input logic [31:0]  mem_wdata,
   input logic         irq_done,
   input logic         irq_err,
   input logic [255:0] hw_ack
);
   localparam logic [255:0] LIVE_MASK = (256'(1) << NUM_HW_CH) - 256'(1);

   a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   a_r11_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_done && irq_err));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_done |=> !irq_done);

   a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |=> !irq_err);

   a_r3_sw_starts: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && sw_start |=> busy);

   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   a_r9_ack_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_ack & ~LIVE_MASK) == 256'd0);

   a_r8_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hw_ack));

   a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> !busy);
endmodule

bind dxfer_ctrl dxfer_ctrl_chk #(.NUM_HW_CH(NUM_HW_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .busy(busy),
   .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .irq_done(irq_done), .irq_err(irq_err), .hw_ack(hw_ack)
);

// File: tb/dxfer_ctrl_bench.sv
`timescale 1ns/1ps
module dxfer_ctrl_bench;
   localparam int NCH = 64;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n, sw_start;
   logic [31:0]  sw_desc_addr, table_base;
   logic [255:0] hw_req, hw_ack;
   logic         mem_req, mem_we, mem_ready, mem_err;
   logic [31:0]  mem_addr, mem_wdata, mem_rdata, err_desc;
   logic         busy, irq_done, irq_err;

   dxfer_ctrl #(.NUM_HW_CH(NCH)) u_dxfer_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_desc_addr(sw_desc_addr),
      .table_base(table_base), .hw_req(hw_req),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ready(mem_ready), .mem_err(mem_err),
      .busy(busy), .irq_done(irq_done), .irq_err(irq_err), .err_desc(err_desc), .hw_ack(hw_ack)
   );

   // memory model
   logic [31:0] mem [0:1023];
   logic        tb_we;
   logic [31:0] tb_wa, tb_wd;
   logic        err_en, wait_mode, rdy;
   logic [31:0] err_at;

   assign mem_rdata = mem[mem_addr[11:2]];
   assign mem_ready = rdy;
   assign mem_err   = mem_req && err_en && (mem_addr == err_at);

   always @(posedge clk) begin
      if (tb_we) mem[tb_wa[11:2]] <= tb_wd;
      else if (mem_req && mem_we && mem_ready && !mem_err) mem[mem_addr[11:2]] <= mem_wdata;
   end
   always @(negedge clk) rdy <= wait_mode ? (($urandom % 3) != 0) : 1'b1;

   int nchk = 0, nerr = 0, cyc = 0;
   logic        ev_done, ev_err;
   logic [255:0] ev_ack;
   int          ev_cyc;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nchk++; nerr++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] src_val(input logic [31:0] a);
      return 32'hA500_0000 ^ (a * 32'h0000_9E37);
   endfunction

   task automatic poke(input logic [31:0] a, input logic [31:0] d);
      tb_we = 1'b1; tb_wa = a; tb_wd = d;
      @(negedge clk);
      tb_we = 1'b0;
   endtask

   task automatic set_desc(input logic [31:0] a, input logic [3:0] c, input int bi, input int bo,
                           input logic [31:0] s, input logic [31:0] d);
      poke(a, {28'd0, c});
      poke(a + 4, {16'(bo), 16'(bi)});
      poke(a + 8, s);
      poke(a + 12, d);
   endtask

   task automatic clear_dst(input logic [31:0] d, input int n);
      for (int k = 0; k < n; k++) poke(d + 32'(4*k), 32'd0);
   endtask

   task automatic wait_evt();
      ev_cyc = 0; ev_done = 0; ev_err = 0; ev_ack = '0;
      while (ev_cyc < 3000) begin
         @(posedge clk); ev_cyc++;
         @(negedge clk);
         if (irq_done || irq_err || (|hw_ack)) begin
            ev_done = irq_done; ev_err = irq_err; ev_ack = hw_ack;
            break;
         end
      end
   endtask

   task automatic start_sw(input logic [31:0] a);
      sw_desc_addr = a; sw_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sw_start = 1'b0;
   endtask

   // checks copy result and write-back against the bench model
   task automatic check_run(input string rq, input logic [31:0] da, input int bi, input int bo,
                            input logic [31:0] s, input logic [31:0] d, input bit irl, input bit orl);
      int nd;
      nd = irl ? bi : bi * bo;
      for (int j = 0; j < nd + 2; j++) begin
         logic [31:0] e;
         e = (j < nd) ? src_val(s + 32'(4*j)) : 32'd0;
         chk(mem[(d + 32'(4*j)) >> 2] == e, irl ? "R5 dst word" : "R2 dst word", mem[(d + 32'(4*j)) >> 2], e);
      end
      if (orl) begin
         chk(mem[(da+4) >> 2] == {16'(bo), 16'(bi)}, "R6 count kept", mem[(da+4) >> 2], {16'(bo), 16'(bi)});
         chk(mem[(da+8) >> 2] == s, "R6 src kept", mem[(da+8) >> 2], s);
      end else begin
         chk(mem[(da+4) >> 2] == 32'd0, "R6 count zero", mem[(da+4) >> 2], 32'd0);
         chk(mem[(da+8) >> 2] == s + 32'(4*nd), "R1 src at +8 written back", mem[(da+8) >> 2], s + 32'(4*nd));
         chk(mem[(da+12) >> 2] == d + 32'(4*nd), "R6 dst written back", mem[(da+12) >> 2], d + 32'(4*nd));
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; sw_start = 0; sw_desc_addr = 0; table_base = 32'h0; hw_req = '0;
      tb_we = 0; tb_wa = 0; tb_wd = 0; err_en = 0; err_at = 0; wait_mode = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk(!busy && !irq_done && !irq_err, "R11 reset idle", {29'd0, busy, irq_done, irq_err}, 32'd0);
      chk(!mem_req && hw_ack == '0, "R11 reset quiet", {31'd0, mem_req}, 32'd0);

      for (int k = 0; k < 1024; k++) poke(32'(4*k), (k >= 512 && k < 576) ? src_val(32'(4*k)) : 32'd0);

      // R3 exact latency, N=2 with write-back
      set_desc(32'h400, 4'b0000, 2, 1, 32'h800, 32'hC00);
      start_sw(32'h400); wait_evt();
      chk(ev_done && ev_cyc == 12, "R3 latency wb", 32'(ev_cyc), 32'd12);
      @(negedge clk);
      chk(!irq_done, "R11 done one cycle", {31'd0, irq_done}, 32'd0);
      // R3 exact latency, N=3 outer reload
      set_desc(32'h400, 4'b1000, 3, 1, 32'h800, 32'hC00);
      start_sw(32'h400); wait_evt();
      chk(ev_done && ev_cyc == 11, "R3 latency outer", 32'(ev_cyc), 32'd11);

      // random runs, some with wait states
      for (int it = 0; it < 12; it++) begin
         int bi, bo; bit irl, orl; logic [31:0] s;
         bi = 1 + int'($urandom % 4); bo = 1 + int'($urandom % 3);
         irl = 1'($urandom % 2); orl = 1'($urandom % 2);
         s = 32'h800 + 32'(4 * ($urandom % 16));
         wait_mode = 1'($urandom % 2);
         clear_dst(32'hC00, 14);
         set_desc(32'h400, {orl, irl, 2'b00}, bi, bo, s, 32'hC00);
         start_sw(32'h400); wait_evt();
         chk(ev_done && !ev_err, wait_mode ? "R4 done under waits" : "R2 done", {30'd0, ev_done, ev_err}, 32'd2);
         check_run(irl ? "R5" : "R2", 32'h400, bi, bo, s, 32'hC00, irl, orl);
      end
      wait_mode = 0;

      // R7 chain to next descriptor
      clear_dst(32'hC00, 4); clear_dst(32'hC40, 5);
      set_desc(32'h500, 4'b0001, 2, 1, 32'h800, 32'hC00);
      set_desc(32'h510, 4'b0000, 3, 1, 32'h840, 32'hC40);
      start_sw(32'h500); wait_evt();
      chk(ev_done, "R7 chain ends with done", {31'd0, ev_done}, 32'd1);
      check_run("R7", 32'h500, 2, 1, 32'h800, 32'hC00, 0, 0);
      check_run("R7", 32'h510, 3, 1, 32'h840, 32'hC40, 0, 0);
      begin
         int extra = 0;
         for (int k = 0; k < 30; k++) begin @(negedge clk); if (irq_done || busy) extra++; end
         chk(extra == 0, "R7 single done pulse", 32'(extra), 32'd0);
      end

      // R7 chain to same: second pass has zero count, moves nothing, stops
      clear_dst(32'hC00, 4);
      set_desc(32'h540, 4'b0011, 2, 1, 32'h820, 32'hC00);
      start_sw(32'h540); wait_evt();
      chk(ev_done, "R7 chain same ends", {31'd0, ev_done}, 32'd1);
      check_run("R7", 32'h540, 2, 1, 32'h820, 32'hC00, 0, 0);

      // R8 lowest channel first, pointer table lookup
      clear_dst(32'hC80, 4);
      poke(32'h00C, 32'h580); poke(32'h014, 32'h5A0);
      set_desc(32'h580, 4'b0000, 1, 1, 32'h800, 32'hC80);
      set_desc(32'h5A0, 4'b0000, 1, 1, 32'h804, 32'hC84);
      hw_req[3] = 1'b1; hw_req[5] = 1'b1;
      wait_evt();
      chk(ev_ack[3] && !ev_ack[5], "R8 channel 3 first", ev_ack[31:0], 32'h8);
      hw_req[3] = 1'b0;
      wait_evt();
      chk(ev_ack[5] && ev_done, "R8 channel 5 next", ev_ack[31:0], 32'h20);
      hw_req[5] = 1'b0;
      chk(mem[32'hC80 >> 2] == src_val(32'h800), "R8 ch3 data", mem[32'hC80 >> 2], src_val(32'h800));
      chk(mem[32'hC84 >> 2] == src_val(32'h804), "R8 ch5 data", mem[32'hC84 >> 2], src_val(32'h804));

      // R8 highest live channel
      poke(32'h0FC, 32'h5C0);
      set_desc(32'h5C0, 4'b0000, 1, 1, 32'h808, 32'hCA0);
      hw_req[63] = 1'b1;
      wait_evt();
      chk(ev_ack[63], "R8 channel 63 served", {31'd0, ev_ack[63]}, 32'd1);
      hw_req[63] = 1'b0;

      // R9 out-of-range channels ignored
      hw_req[64] = 1'b1; hw_req[200] = 1'b1;
      begin
         int act = 0;
         for (int k = 0; k < 40; k++) begin @(negedge clk); if (busy || mem_req || (|hw_ack)) act++; end
         chk(act == 0, "R9 high channels ignored", 32'(act), 32'd0);
      end
      hw_req[64] = 1'b0; hw_req[200] = 1'b0;

      // R3 software beats a simultaneous hardware request
      poke(32'h008, 32'h5E0);
      set_desc(32'h5E0, 4'b0000, 1, 1, 32'h80C, 32'hCB0);
      set_desc(32'h620, 4'b0000, 1, 1, 32'h810, 32'hCB4);
      hw_req[2] = 1'b1;
      start_sw(32'h620); wait_evt();
      chk(ev_done && ev_ack == '0, "R3 software first", ev_ack[31:0], 32'd0);
      wait_evt();
      chk(ev_ack[2], "R8 channel 2 after software", ev_ack[31:0], 32'h4);
      hw_req[2] = 1'b0;

      // R10 bus error on second source read
      clear_dst(32'hCC0, 3);
      set_desc(32'h600, 4'b0000, 3, 1, 32'h800, 32'hCC0);
      err_at = 32'h804; err_en = 1'b1;
      start_sw(32'h600); wait_evt();
      err_en = 1'b0;
      chk(ev_err && !ev_done, "R10 error pulse only", {30'd0, ev_done, ev_err}, 32'd1);
      chk(err_desc == 32'h600, "R10 failing descriptor", err_desc, 32'h600);
      chk(mem[32'h604 >> 2] == 32'h0001_0003, "R10 no write-back", mem[32'h604 >> 2], 32'h0001_0003);
      chk(mem[32'hCC0 >> 2] == src_val(32'h800), "R10 first beat done", mem[32'hCC0 >> 2], src_val(32'h800));
      chk(mem[32'hCC4 >> 2] == 32'd0, "R10 later beats skipped", mem[32'hCC4 >> 2], 32'd0);
      @(negedge clk);
      chk(!irq_err && !busy, "R11 error one cycle", {30'd0, irq_err, busy}, 32'd0);

      summary();
   end
endmodule